// File: doc/BRIEF.md
# Exact-Count Word Bus Access Sequencer

This block turns one processor-side access of one, two or three bytes at an arbitrary byte address into a short series of cycles on a 16-bit peripheral bus. That bus offers three cycle types: word read, word write and byte write. Peripheral registers can change state when they are read, so the sequencer issues only the bus cycles the access actually needs. It never turns a byte store into a word read-modify-write.

A request is offered on a one-cycle start strobe together with the address, the length, the direction and up to 24 bits of right-aligned write data. The sequencer then presents one or two bus cycles. Each cycle is held until the bus acknowledges it. A single-cycle done pulse follows the last acknowledge. For reads, the returned words are assembled into a 32-bit longword image. The requester extracts bytes from that image itself.

Top module: `exactWordBusSeq`

## Requirements
- R1: After reset, `busReq`, `done` and `rdResult` are all zero.
- R2: A start is accepted only when the sequencer is idle and `reqLen` is nonzero. A start while a bus cycle or done is in progress, or with `reqLen` = 0, produces no bus cycle and no done pulse.
- R3: A read (`reqWrite` = 0) issues one word-read cycle at the address when `reqLen` + `reqAddr[0]` ≤ 2. Otherwise it issues two word reads, first at the address and then at the address + 2. Read cycles always show `busWrite` = 0 and `busByte` = 0.
- R4: After a single-cycle read, the word appears in `rdResult[31:16]` when `reqAddr[1]` = 1, and in `rdResult[15:0]` otherwise. The other half is zero.
- R5: After a two-cycle read, `rdResult` holds the second word in bits 31:16 and the first word in bits 15:0.
- R6: A write with `reqLen` = 1 issues exactly one byte write (`busWrite` = 1, `busByte` = 1) at the address. `busWrData[7:0]` carries the data and `busWrData[15:8]` is zero. This zero-fill applies to every byte write.
- R7: A two-byte write at an even address issues one word write of data bits 15:0. At an odd address it issues a byte write of bits 7:0 at the address, then a byte write of bits 15:8 at the address + 1.
- R8: A three-byte write at an odd address issues a byte write of bits 7:0 at the address, then a word write of bits 23:8 at the address + 1.
- R9: A three-byte write at an even address issues a word write of bits 15:0 at the address, then a byte write of bits 23:16 at the address + 2.
- R10: The first bus cycle is requested in the clock cycle after the accepted start. A request and its address, data and flags stay unchanged until `busAck`. A second cycle is requested in the clock cycle right after the first acknowledge.
- R11: `done` is high for exactly one clock cycle, in the cycle after the final acknowledge, with `busReq` low. `rdResult` holds its value from then until the next read updates it.
- R12: A read of length 1 still returns the whole 16-bit word in its half of `rdResult`, with no byte extraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start strobe for one access |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqLen | input | 2 | Length in bytes (1 to 3, 0 is ignored) |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqData | input | 24 | Right-aligned write data |
| busReq | output | 1 | Bus cycle request |
| busAddr | output | ADDR_W | Byte address of the current bus cycle |
| busWrite | output | 1 | Current cycle is a write |
| busByte | output | 1 | Current write is a byte write |
| busWrData | output | 16 | Write data (byte writes in bits 7:0) |
| busAck | input | 1 | Bus acknowledge of the current cycle |
| busRdData | input | 16 | Read word, valid with busAck |
| done | output | 1 | One-cycle completion pulse |
| rdResult | output | 32 | Longword image assembled from the read words |

## Verification
The bench drives a start at a falling edge. The first bus request is due in the next cycle. Each later request is due in the cycle after the previous acknowledge, and done with the result is due in the cycle after the last acknowledge. A behavioural model queues the expected bus cycles for each request, and the outputs are compared against that queue at every falling edge while acknowledges are withheld for a varying number of cycles. For the ignored starts, the bench checks in the following cycles that the queue stays as expected, that no extra bus cycle appears and that done stays low.

// File: rtl/seqPkg.sv
package seqPkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_FINISH = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new request
    logic capFirst;   // first bus cycle acknowledged
    logic capSecond;  // second bus cycle acknowledged
    logic phase2;     // second bus cycle is being presented
  } seqStrobe_t;
endpackage

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqLen,
  input  logic       needTwo,
  input  logic       busAck,
  output seqStrobe_t strobe,
  output logic       busReq,
  output logic       done
);
  seqState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid && (reqLen != 2'd0)) begin
          strobe.load = 1'b1;
          stateD = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (busAck) begin
          strobe.capFirst = 1'b1;
          stateD = needTwo ? ST_SECOND : ST_FINISH;
        end
      end
      ST_SECOND: begin
        strobe.phase2 = 1'b1;
        if (busAck) begin
          strobe.capSecond = 1'b1;
          stateD = ST_FINISH;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busReq = (stateQ == ST_FIRST) || (stateQ == ST_SECOND);
  assign done   = (stateQ == ST_FINISH);

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq); // R10
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busReq && busAck)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq); // R11
  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busReq && !done && reqValid && reqLen == 2'd0 |=> !busReq); // R2
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqLen,
  input  logic                reqWrite,
  input  logic [3*WORD_W/2-1:0] reqData,
  input  logic [WORD_W-1:0]   busRdData,
  output logic                needTwo,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                busWrite,
  output logic                busByte,
  output logic [WORD_W-1:0]   busWrData,
  output logic [2*WORD_W-1:0] rdResult
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int DATA_W = 3 * BYTE_W;
  localparam int RES_W  = 2 * WORD_W;
  localparam int WORD_BYTES = WORD_W / BYTE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        lenQ;
  logic              wrQ;
  logic [DATA_W-1:0] dataQ;
  logic [WORD_W-1:0] firstWordQ;
  logic [RES_W-1:0]  resultQ;
  logic              oddAddr;

  assign oddAddr = addrQ[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ      <= '0;
      lenQ       <= '0;
      wrQ        <= 1'b0;
      dataQ      <= '0;
      firstWordQ <= '0;
      resultQ    <= '0;
    end else begin
      if (strobe.load) begin
        addrQ <= reqAddr;
        lenQ  <= reqLen;
        wrQ   <= reqWrite;
        dataQ <= reqData;
      end
      if (strobe.capFirst && !wrQ) begin
        firstWordQ <= busRdData;
        if (!needTwo)
          resultQ <= addrQ[1] ? {busRdData, {WORD_W{1'b0}}}
                              : {{WORD_W{1'b0}}, busRdData};
      end
      if (strobe.capSecond && !wrQ)
        resultQ <= {busRdData, firstWordQ};
    end
  end

  // cycle count: reads span words by length plus address parity
  always_comb begin
    if (!wrQ) needTwo = ({1'b0, lenQ} + {2'b00, oddAddr}) > 3'd2;
    else      needTwo = (lenQ == 2'd3) || ((lenQ == 2'd2) && oddAddr);
  end

  always_comb begin
    busAddr   = addrQ;
    busByte   = 1'b0;
    busWrData = '0;
    if (!wrQ) begin
      if (strobe.phase2) busAddr = addrQ + ADDR_W'(WORD_BYTES);
    end else begin
      unique case (lenQ)
        2'd2: begin
          if (oddAddr) begin
            busByte = 1'b1;
            if (strobe.phase2) begin
              busAddr   = addrQ + ADDR_W'(1);
              busWrData = {{BYTE_W{1'b0}}, dataQ[2*BYTE_W-1:BYTE_W]};
            end else begin
              busWrData = {{BYTE_W{1'b0}}, dataQ[BYTE_W-1:0]};
            end
          end else begin
            busWrData = dataQ[WORD_W-1:0];
          end
        end
        2'd3: begin
          if (oddAddr) begin
            if (strobe.phase2) begin
              busAddr   = addrQ + ADDR_W'(1);
              busWrData = dataQ[DATA_W-1:BYTE_W];
            end else begin
              busByte   = 1'b1;
              busWrData = {{BYTE_W{1'b0}}, dataQ[BYTE_W-1:0]};
            end
          end else begin
            if (strobe.phase2) begin
              busAddr   = addrQ + ADDR_W'(WORD_BYTES);
              busByte   = 1'b1;
              busWrData = {{BYTE_W{1'b0}}, dataQ[DATA_W-1:2*BYTE_W]};
            end else begin
              busWrData = dataQ[WORD_W-1:0];
            end
          end
        end
        default: begin
          busByte   = 1'b1;
          busWrData = {{BYTE_W{1'b0}}, dataQ[BYTE_W-1:0]};
        end
      endcase
    end
  end

  assign busWrite = wrQ;
  assign rdResult = resultQ;

  AST_SECOND_NEEDED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capSecond |-> needTwo); // R3
  AST_CYCLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.phase2 && !strobe.capSecond |=> $stable(busAddr) && $stable(busWrData)); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capFirst && !strobe.capSecond |=> $stable(rdResult)); // R11
endmodule

// File: rtl/exactWordBusSeq.sv
module exactWordBusSeq
  import seqPkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int WORD_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [1:0]             reqLen,
  input  logic                   reqWrite,
  input  logic [3*WORD_W/2-1:0]  reqData,
  output logic                   busReq,
  output logic [ADDR_W-1:0]      busAddr,
  output logic                   busWrite,
  output logic                   busByte,
  output logic [WORD_W-1:0]      busWrData,
  input  logic                   busAck,
  input  logic [WORD_W-1:0]      busRdData,
  output logic                   done,
  output logic [2*WORD_W-1:0]    rdResult
);
  seqStrobe_t strobe;
  logic       needTwo;

  seqControl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .needTwo(needTwo), .busAck(busAck), .strobe(strobe),
    .busReq(busReq), .done(done)
  );

  seqDatapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWrite(reqWrite), .reqData(reqData),
    .busRdData(busRdData), .needTwo(needTwo), .busAddr(busAddr),
    .busWrite(busWrite), .busByte(busByte), .busWrData(busWrData),
    .rdResult(rdResult)
  );

  AST_BYTE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWrite |-> !busByte); // R3
endmodule

// File: tb/test_exactWordBusSeq.sv
module test_exactWordBusSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [1:0]  reqLen = '0;
  logic        reqWrite = 1'b0;
  logic [23:0] reqData = '0;
  logic        busReq, busWrite, busByte, done;
  logic [21:0] busAddr;
  logic [15:0] busWrData;
  logic        busAck = 1'b0;
  logic [15:0] busRdData = '0;
  logic [31:0] rdResult;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  exactWordBusSeq i_exactWordBusSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWrite(reqWrite), .reqData(reqData),
    .busReq(busReq), .busAddr(busAddr), .busWrite(busWrite),
    .busByte(busByte), .busWrData(busWrData), .busAck(busAck),
    .busRdData(busRdData), .done(done), .rdResult(rdResult)
  );

  function automatic logic [15:0] memWord(input logic [21:0] a);
    return 16'((a * 37) ^ 16'hC3A5);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // run one access; wait = cycles of withheld ack per bus cycle; probe = try a start while busy
  task automatic runOp(input logic [21:0] a, input logic [1:0] len, input logic wr,
                       input logic [23:0] d, input int waitCyc, input bit probe, input string tag);
    logic [21:0] qA[$];
    logic [15:0] qD[$];
    logic        qB[$];
    logic [31:0] expRes;
    int n;
    // behavioural model of the expected cycle list
    if (!wr) begin
      qA.push_back(a); qD.push_back(16'h0); qB.push_back(1'b0);
      if (int'(len) + int'(a[0]) > 2) begin
        qA.push_back(a + 22'd2); qD.push_back(16'h0); qB.push_back(1'b0);
        expRes = {memWord(a + 22'd2), memWord(a)};
      end else begin
        expRes = a[1] ? {memWord(a), 16'h0} : {16'h0, memWord(a)};
      end
    end else if (len == 2'd1) begin
      qA.push_back(a); qD.push_back({8'h0, d[7:0]}); qB.push_back(1'b1);
    end else if (len == 2'd2 && !a[0]) begin
      qA.push_back(a); qD.push_back(d[15:0]); qB.push_back(1'b0);
    end else if (len == 2'd2) begin
      qA.push_back(a); qD.push_back({8'h0, d[7:0]}); qB.push_back(1'b1);
      qA.push_back(a + 22'd1); qD.push_back({8'h0, d[15:8]}); qB.push_back(1'b1);
    end else if (a[0]) begin
      qA.push_back(a); qD.push_back({8'h0, d[7:0]}); qB.push_back(1'b1);
      qA.push_back(a + 22'd1); qD.push_back(d[23:8]); qB.push_back(1'b0);
    end else begin
      qA.push_back(a); qD.push_back(d[15:0]); qB.push_back(1'b0);
      qA.push_back(a + 22'd2); qD.push_back({8'h0, d[23:16]}); qB.push_back(1'b1);
    end
    n = qA.size();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqLen = len; reqWrite = wr; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    while (qA.size() > 0) begin
      for (int w = 0; w <= waitCyc; w++) begin
        check(busReq, 1, {tag, " R10 request held"});
        check(done, 0, {tag, " R11 no done during cycle"});
        check(busAddr, qA[0], {tag, " address"});
        check(busWrite, wr, {tag, " direction"});
        check(busByte, qB[0], {tag, " byte flag"});
        if (wr) check(busWrData, qD[0], {tag, " write data"});
        if (probe && w == 0) begin
          reqValid = 1'b1; reqAddr = 22'h3F0; reqLen = 2'd3; reqWrite = ~wr; reqData = 24'hFFFFFF;
        end else begin
          reqValid = 1'b0;
        end
        if (w == waitCyc) begin
          busAck = 1'b1;
          busRdData = memWord(busAddr);
        end
        @(negedge clk);
        busAck = 1'b0;
        busRdData = 16'h0;
      end
      void'(qA.pop_front()); void'(qD.pop_front()); void'(qB.pop_front());
    end
    reqValid = 1'b0;
    check(done, 1, {tag, " R11 done after last ack"});
    check(busReq, 0, {tag, " R11 no request with done"});
    if (!wr) check(rdResult, expRes, {tag, " result"});
    @(negedge clk);
    check(done, 0, {tag, " R11 done one cycle"});
    check(busReq, 0, {tag, " R2 no extra cycle"});
    if (!wr) check(rdResult, expRes, {tag, " R11 result held"});
    if (n == 0) check(0, 1, {tag, " empty model"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busReq, 0, "R1 reset busReq");
    check(done, 0, "R1 reset done");
    check(rdResult, 0, "R1 reset rdResult");
    rstN = 1'b1;
    @(negedge clk);

    // length zero is ignored (R2)
    reqValid = 1'b1; reqAddr = 22'h40; reqLen = 2'd0; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(busReq, 0, "R2 zero length no cycle");
      check(done, 0, "R2 zero length no done");
      @(negedge clk);
    end

    runOp(22'h011, 2'd1, 1'b0, 24'h0, 0, 0, "R12 R4 byte read low half");
    runOp(22'h013, 2'd1, 1'b0, 24'h0, 2, 0, "R12 R4 byte read upper half");
    runOp(22'h012, 2'd2, 1'b0, 24'h0, 1, 0, "R4 word read upper");
    runOp(22'h020, 2'd2, 1'b0, 24'h0, 0, 0, "R3 R4 word read lower");
    runOp(22'h011, 2'd2, 1'b0, 24'h0, 1, 1, "R3 R5 R2 odd word read");
    runOp(22'h020, 2'd3, 1'b0, 24'h0, 0, 0, "R3 R5 even tri read");
    runOp(22'h033, 2'd3, 1'b0, 24'h0, 3, 0, "R3 R5 odd tri read");
    runOp(22'h101, 2'd1, 1'b1, 24'hABCD5A, 0, 0, "R6 byte write odd");
    runOp(22'h102, 2'd1, 1'b1, 24'h1234C3, 1, 1, "R6 R2 byte write even");
    runOp(22'h104, 2'd2, 1'b1, 24'h00BEEF, 0, 0, "R7 even word write");
    runOp(22'h107, 2'd2, 1'b1, 24'h00CAFE, 2, 0, "R7 odd word write");
    runOp(22'h109, 2'd3, 1'b1, 24'h123456, 1, 0, "R8 odd tri write");
    runOp(22'h10A, 2'd3, 1'b1, 24'h789ABC, 0, 1, "R9 R2 even tri write");
    runOp(22'h3FFFFF, 2'd3, 1'b1, 24'hA1B2C3, 0, 0, "R8 wrap tri write");
    finishRun();
  end
endmodule